// File: doc/BRIEF.md
# Integer Execute Stage

This block performs the single-cycle integer arithmetic, logic, shift and compare operations of a 32-bit processor pipeline. Each cycle the decode stage may present an instruction word together with the two source operand values already read from the register file, and raise a strobe. The block decodes the major opcode, the 3-bit function field and the 7-bit function field. It forms either the sign-extended 12-bit immediate or the second register operand, computes the result, and registers it one cycle later. The registered result comes with a destination index, a write enable and an illegal-instruction flag.

Only two major opcodes are accepted: 7'h33 for register-register operations and 7'h13 for register-immediate operations. Any other opcode is flagged as illegal. The function field at bits [14:12] selects the operation: 0 add or subtract, 1 left shift, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 right shift, 6 or, 7 and. The 7-bit field at bits [31:25] selects between variants. A value of 7'h00 is the plain form and 7'h20 is the alternate form (subtract, or arithmetic right shift). When the block raises the illegal flag, it blocks the register write and leaves the trap to downstream logic.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `wr_en` and `illegal` are 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high and 0 otherwise. `wr_en` and `illegal` are never 1 while `out_valid` is 0.
- R3: Add (function 0) and subtract (function 0 with bits [31:25] = 7'h20, register form only) wrap modulo 2^32 without overflow detection. The immediate form always adds the sign-extended bits [31:20].
- R4: Register shifts take the amount from `src_b[4:0]`. Function 1 shifts left. Function 5 shifts right logically when bits [31:25] = 7'h00 and arithmetically when they are 7'h20.
- R5: Immediate shifts take the amount from instruction bits [24:20], and bits [31:25] select logical (7'h00) or arithmetic (7'h20) right shift.
- R6: The less-than operations produce exactly 0 or 1. Function 2 compares signed and function 3 compares unsigned. In the immediate form, the sign-extended immediate is reinterpreted as an unsigned 32-bit value for function 3.
- R7: Functions 4, 6 and 7 give bitwise xor, or and and with `src_b` or with the sign-extended immediate.
- R8: Any bits [31:25] other than 7'h00 on register operations, other than 7'h00/7'h20 on function 0 or 5 of register operations, or other than 7'h00/7'h20 on the immediate right shift or 7'h00 on the immediate left shift, raise `illegal` with `wr_en` 0 and `result` 0.
- R9: An opcode other than 7'h33 or 7'h13 raises `illegal` with `wr_en` 0 and `result` 0.
- R10: A legal operation whose destination bits [11:7] are 0 gives `wr_en` 0 and `illegal` 0.
- R11: `wr_idx` equals instruction bits [11:7] of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| out_valid | output | 1 | Registered outputs belong to an accepted instruction |
| result | output | 32 | Computed result (0 on illegal) |
| wr_en | output | 1 | Write the result to the destination register |
| wr_idx | output | 5 | Destination register index |
| illegal | output | 1 | Accepted instruction is not a legal encoding |

## Verification
Every result, the write enable, the destination index and the illegal flag are due exactly one clock edge after the strobe that carried the instruction, together with `out_valid`. Nothing is combinational from input to output. The bench changes inputs on falling edges, lets a single rising edge capture them, and compares all outputs at the following falling edge. It also checks that `out_valid` drops one edge after the strobe is removed and that back-to-back strobes produce results on consecutive cycles.

// File: rtl/int_exec_unit.sv
module int_exec_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        wr_en,
  output logic [4:0]  wr_idx,
  output logic        illegal
);

  localparam logic [6:0] OPC_REG = 7'h33;
  localparam logic [6:0] OPC_IMM = 7'h13;
  localparam logic [6:0] F7_BASE = 7'h00;
  localparam logic [6:0] F7_ALT  = 7'h20;

  logic [6:0]  opc;
  logic [2:0]  fn3;
  logic [6:0]  fn7;
  logic [4:0]  rd;
  logic [31:0] imm;
  logic        is_reg, is_imm;
  logic        f7_zero, f7_alt;
  logic [31:0] opb;
  logic [4:0]  shamt;
  logic        do_sub;
  logic        legal;
  logic [31:0] value;

  assign opc     = instr[6:0];
  assign rd      = instr[11:7];
  assign fn3     = instr[14:12];
  assign fn7     = instr[31:25];
  assign imm     = {{20{instr[31]}}, instr[31:20]};
  assign is_reg  = (opc == OPC_REG);
  assign is_imm  = (opc == OPC_IMM);
  assign f7_zero = (fn7 == F7_BASE);
  assign f7_alt  = (fn7 == F7_ALT);
  assign opb     = is_reg ? src_b : imm;
  assign shamt   = is_reg ? src_b[4:0] : instr[24:20];
  assign do_sub  = is_reg && f7_alt && (fn3 == 3'd0);

  always_comb begin
    case (fn3)
      3'd0:    legal = is_imm || (is_reg && (f7_zero || f7_alt));
      3'd1:    legal = (is_imm || is_reg) && f7_zero;
      3'd5:    legal = (is_imm || is_reg) && (f7_zero || f7_alt);
      default: legal = is_imm || (is_reg && f7_zero);
    endcase
  end

  always_comb begin
    case (fn3)
      3'd0:    value = do_sub ? (src_a - opb) : (src_a + opb);
      3'd1:    value = src_a << shamt;
      3'd2:    value = {31'd0, ($signed(src_a) < $signed(opb))};
      3'd3:    value = {31'd0, (src_a < opb)};
      3'd4:    value = src_a ^ opb;
      3'd5:    value = f7_alt ? $unsigned($signed(src_a) >>> shamt) : (src_a >> shamt);
      3'd6:    value = src_a | opb;
      default: value = src_a & opb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= legal ? value : 32'd0;
        wr_en   <= legal && (rd != 5'd0);
        wr_idx  <= rd;
        illegal <= !legal;
      end else begin
        wr_en   <= 1'b0;
        illegal <= 1'b0;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || illegal) |-> out_valid);
  assert_no_write_on_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_en && result == 32'd0));
  assert_unknown_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_reg && !is_imm) |=> (illegal && !wr_en));
  assert_x0_not_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != 5'd0));
  assert_compare_binary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal && (fn3 == 3'd2 || fn3 == 3'd3)) |=> (result[31:1] == 31'd0));

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  int_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .wr_idx(wr_idx), .illegal(illegal)
  );

  function automatic logic [31:0] rt(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, 5'd2, 5'd1, f3, rd, 7'h33};
  endfunction

  function automatic logic [31:0] it(input logic [11:0] im, input logic [2:0] f3, input logic [4:0] rd);
    return {im, 5'd1, f3, rd, 7'h13};
  endfunction

  localparam int NV = 24;
  localparam logic [31:0] V_INSTR [NV] = '{
    rt(7'h00, 3'd0, 5'd5),  rt(7'h20, 3'd0, 5'd5),  it(12'hfff, 3'd0, 5'd5),   // R3
    rt(7'h00, 3'd1, 5'd5),  rt(7'h00, 3'd5, 5'd5),  rt(7'h20, 3'd5, 5'd5),     // R4
    it({7'h00, 5'd31}, 3'd1, 5'd5), it({7'h00, 5'd8}, 3'd5, 5'd5), it({7'h20, 5'd8}, 3'd5, 5'd5), // R5
    rt(7'h00, 3'd2, 5'd5),  rt(7'h00, 3'd3, 5'd5),  it(12'h800, 3'd2, 5'd5), it(12'hfff, 3'd3, 5'd5), // R6
    rt(7'h00, 3'd4, 5'd5),  it(12'h800, 3'd6, 5'd5), it(12'h0ff, 3'd7, 5'd5),
    rt(7'h00, 3'd7, 5'd5),  rt(7'h00, 3'd6, 5'd5),                              // R7
    rt(7'h01, 3'd0, 5'd5),  rt(7'h20, 3'd1, 5'd5),  it({7'h01, 5'd3}, 3'd5, 5'd5), // R8
    32'h0000_0283,                                                             // R9
    rt(7'h00, 3'd0, 5'd0),                                                     // R10
    rt(7'h00, 3'd0, 5'd31)                                                     // R11
  };
  localparam logic [31:0] V_A [NV] = '{
    32'h7fffffff, 32'h0, 32'h0,
    32'h1, 32'h80000000, 32'h80000000,
    32'h1, 32'hff000000, 32'hff000000,
    32'hffffffff, 32'hffffffff, 32'h0, 32'h5,
    32'hf0f0f0f0, 32'h1, 32'h12345678, 32'hffff0000, 32'h1,
    32'h1, 32'h1, 32'h1,
    32'h1,
    32'h1,
    32'h10
  };
  localparam logic [31:0] V_B [NV] = '{
    32'h1, 32'h1, 32'h0,
    32'h23, 32'h4, 32'h4,
    32'h0, 32'h0, 32'h0,
    32'h1, 32'h1, 32'h0, 32'h0,
    32'hff00ff00, 32'h0, 32'h0, 32'h0ff00ff0, 32'h2,
    32'h2, 32'h2, 32'h2,
    32'h2,
    32'h2,
    32'h20
  };
  localparam logic [31:0] V_RES [NV] = '{
    32'h80000000, 32'hffffffff, 32'hffffffff,
    32'h8, 32'h08000000, 32'hf8000000,
    32'h80000000, 32'h00ff0000, 32'hffff0000,
    32'h1, 32'h0, 32'h0, 32'h1,
    32'h0ff00ff0, 32'hfffff801, 32'h78, 32'h0ff00000, 32'h3,
    32'h0, 32'h0, 32'h0,
    32'h0,
    32'h3,
    32'h30
  };
  localparam logic V_WE [NV] = '{
    1,1,1, 1,1,1, 1,1,1, 1,1,1,1, 1,1,1,1,1, 0,0,0, 0, 0, 1 };
  localparam logic V_ILL [NV] = '{
    0,0,0, 0,0,0, 0,0,0, 0,0,0,0, 0,0,0,0,0, 1,1,1, 1, 0, 0 };
  localparam int V_REQ [NV] = '{
    3,3,3, 4,4,4, 5,5,5, 6,6,6,6, 7,7,7,7,7, 8,8,8, 9, 10, 11 };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    instr = ins; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1", "wr_en in reset", {31'd0, wr_en}, 32'd0);
    check("R1", "illegal in reset", {31'd0, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", V_REQ[i], i);
      present(V_INSTR[i], V_A[i], V_B[i]);
      check(tag, "out_valid", {31'd0, out_valid}, 32'd1);
      check(tag, "result", result, V_RES[i]);
      check(tag, "wr_en", {31'd0, wr_en}, {31'd0, V_WE[i]});
      check(tag, "illegal", {31'd0, illegal}, {31'd0, V_ILL[i]});
      if (V_WE[i]) check(tag, "wr_idx", {27'd0, wr_idx}, {27'd0, V_INSTR[i][11:7]});
    end

    in_valid = 1'b0;
    @(negedge clk);
    check("R2", "out_valid after strobe removed", {31'd0, out_valid}, 32'd0);
    check("R2", "wr_en idle", {31'd0, wr_en}, 32'd0);

    present(rt(7'h01, 3'd5, 5'd7), 32'h8, 32'h1);
    check("R8", "illegal srl variant", {31'd0, illegal}, 32'd1);
    check("R8", "no write srl variant", {31'd0, wr_en}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", "illegal cleared when idle", {31'd0, illegal}, 32'd0);

    present(it(12'h7ff, 3'd0, 5'd9), 32'h1, 32'h0);
    check("R3", "add max positive imm", result, 32'h800);
    check("R11", "dest index 9", {27'd0, wr_idx}, 32'd9);
    present(it({7'h00, 5'd0}, 3'd1, 5'd0), 32'hdead, 32'h0);
    check("R10", "x0 shift no write", {31'd0, wr_en}, 32'd0);
    check("R10", "x0 shift not illegal", {31'd0, illegal}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule